// File: doc/BRIEF.md
# Multichannel Result Register Ready Tracker

This block sits in the host-facing side of a multichannel converter. It holds one result register per channel and one ready flag per channel. It drives a single active-low ready pin. Conversion results arrive on a valid/ready stream carrying a channel index and a 24-bit word. The host reads a channel register by pulsing a read-start with a channel index, taking the captured word, and later pulsing a read-end. The ready flags can be read directly at any time.

A ready flag drops as soon as the host starts reading that channel. A result aimed at a channel that is being read is thrown away, so a read never sees a half-changed register. Calibration holds every flag low and then raises them all. A mode-register write clears every flag. The ready pin has two functions, chosen by a configuration bit:
- it asserts when any channel holds unread data;
- it asserts only once every channel in an enable mask holds unread data.

Results are stored either at full width or as their upper 16 bits.

Result stream back-pressure rules:
- `res_ready` is low for as long as a calibration runs.
- A result is taken on any clock where `res_valid` and `res_ready` are both high.
- While `res_ready` is low, the source must hold its word.
- A taken result may still be discarded by the rules below. Discarding never stalls the stream.

Top module: `chan_result_tracker`

## Requirements
- R1: After reset all eight flags are 0 and `rdy_n` is 1. Every register reads 0x8000 with `cfg_wide`=0 and 0x800000 with `cfg_wide`=1.
- R2: A result taken for channel n drives flag bit n (bit n of `stat_flags` belongs to channel n) to 0 at the next edge. At the edge after that, the register is written and flag n becomes 1. This also applies when the earlier result on that channel was never read.
- R3: A `rd_start` for channel n clears flag n at the next edge. From that edge until the next `rd_start`, `rd_data` holds that channel's register, formatted by the width in force at `rd_start`.
- R4: A result for the channel named by a read is discarded: the register keeps its old value and the flag stays 0. This holds while the read is active, from the `rd_start` cycle through the `rd_end` cycle. It also holds when the read starts in the cycle the result would be written.
- R5: With `cfg_wide`=0, a result stores its bits [23:8], and a read returns them zero-extended to 24 bits. With `cfg_wide`=1, all 24 bits are stored and returned.
- R6: `mode_wr` clears all flags at the next edge. It also discards a result taken in that cycle or waiting to be written.
- R7: While `cal_busy` is 1, the flags read 0 from the next edge onward, and any pending result is discarded. A `cal_done` pulse with `cal_busy` low sets all eight flags to 1 at the next edge.
- R8: With `cfg_all`=0, `rdy_n` is low exactly when, one edge earlier, at least one flag was 1.
- R9: With `cfg_all`=1, `rdy_n` is low only when, one edge earlier, every channel with a 1 in `chan_en` had its flag set. When `chan_en` is 0, `rdy_n` stays 1.
- R10: `res_ready` is the inverse of `cal_busy`. A result offered during calibration is not taken and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1: 24-bit results, 0: 16-bit results |
| cfg_all | input | 1 | Ready pin function, 0: any unread, 1: all enabled unread |
| chan_en | input | 8 | Enabled-channel mask for the all-enabled function |
| mode_wr | input | 1 | Mode-register write strobe |
| cal_busy | input | 1 | Calibration running |
| cal_done | input | 1 | Calibration finished pulse |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_chan | input | 3 | Result channel index |
| res_data | input | 24 | Result word |
| rd_start | input | 1 | Host read of a channel register begins |
| rd_end | input | 1 | Host read ends |
| rd_chan | input | 3 | Channel index for `rd_start` |
| rd_data | output | 24 | Captured register value |
| stat_flags | output | 8 | Ready flags, bit n for channel n |
| rdy_n | output | 1 | Registered active-low ready pin |

## Verification
The bench targets the collisions between results and reads:
- **Result during an open read.** A result lands on a channel whose read is open, or whose read starts in the very cycle the staged result would be written. A design that writes it anyway hands the host a changed value on the next read, or raises a flag nobody will clear.
- **Overwrite of unread data.** A design without the low-then-high step on an overwrite shows a steady 1 where a 0 is due.
- **Mode write and calibration.** These must beat a pending result. Getting this wrong leaves a flag set right after a clear.
- **Ready pin timing and mask.** The pin is checked for its one-edge lag and for an empty mask. A combinational or mask-ignoring pin asserts early or asserts at all.

// File: rtl/tracker_pkg.sv
package tracker_pkg;
  typedef enum logic {
    PIN_ANY = 1'b0,
    PIN_ALL = 1'b1
  } pin_mode_e;

  localparam int unsigned DEF_NCH = 8;
  localparam int unsigned DEF_DW  = 24;
  localparam int unsigned DEF_NW  = 16;
endpackage

// File: rtl/result_stage.sv
module result_stage #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 24,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic [CW-1:0] res_chan,
  input  logic [DW-1:0] res_data,
  input  logic          cal_busy,
  input  logic          mode_wr,
  input  logic          rd_start,
  input  logic [CW-1:0] rd_chan,
  input  logic          rd_active,
  input  logic [CW-1:0] rd_sel,
  output logic          acc_pulse,
  output logic [CW-1:0] acc_chan,
  output logic          cmt_pulse,
  output logic [CW-1:0] cmt_chan,
  output logic [DW-1:0] cmt_data
);
  logic          stg_v;
  logic [CW-1:0] stg_chan;
  logic [DW-1:0] stg_data;
  logic          in_busy;
  logic          stg_busy;
  logic          take;

  function automatic logic chan_busy(input logic [CW-1:0] ch,
                                     input logic act, input logic [CW-1:0] sel,
                                     input logic st, input logic [CW-1:0] sch);
    return (act && (sel == ch)) || (st && (sch == ch));
  endfunction

  assign res_ready = !cal_busy;
  assign in_busy   = chan_busy(res_chan, rd_active, rd_sel, rd_start, rd_chan);
  assign stg_busy  = chan_busy(stg_chan, rd_active, rd_sel, rd_start, rd_chan);
  assign take      = res_valid && res_ready && !in_busy;

  assign acc_pulse = take;
  assign acc_chan  = res_chan;
  assign cmt_pulse = stg_v && !stg_busy && !mode_wr && !cal_busy;
  assign cmt_chan  = stg_chan;
  assign cmt_data  = stg_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v    <= 1'b0;
      stg_chan <= '0;
      stg_data <= '0;
    end else begin
      stg_v <= take && !mode_wr && !cal_busy;
      if (take) begin
        stg_chan <= res_chan;
        stg_data <= res_data;
      end
    end
  end
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 24,
  parameter int unsigned NW  = 16,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned PW = DW - NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide,
  input  logic          cmt_pulse,
  input  logic [CW-1:0] cmt_chan,
  input  logic [DW-1:0] cmt_data,
  input  logic          rd_start,
  input  logic          rd_end,
  input  logic [CW-1:0] rd_chan,
  output logic          rd_active,
  output logic [CW-1:0] rd_sel,
  output logic [DW-1:0] rd_data
);
  localparam logic [DW-1:0] RST_WORD = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] bank [NCH];
  logic [DW-1:0] store_word;
  logic [DW-1:0] picked;

  assign store_word = cfg_wide ? cmt_data : {cmt_data[DW-1:PW], {PW{1'b0}}};
  assign picked     = bank[rd_chan];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank[g] <= RST_WORD;
        else if (cmt_pulse && (cmt_chan == CW'(g)))
          bank[g] <= store_word;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_sel    <= '0;
      rd_data   <= '0;
    end else begin
      if (rd_start) begin
        rd_active <= 1'b1;
        rd_sel    <= rd_chan;
        rd_data   <= cfg_wide ? picked : {{PW{1'b0}}, picked[DW-1:PW]};
      end else if (rd_end) begin
        rd_active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ready_flags.sv
module ready_flags #(
  parameter int unsigned NCH = 8,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cal_busy,
  input  logic           cal_done,
  input  logic           mode_wr,
  input  logic           rd_start,
  input  logic [CW-1:0]  rd_chan,
  input  logic           acc_pulse,
  input  logic [CW-1:0]  acc_chan,
  input  logic           cmt_pulse,
  input  logic [CW-1:0]  cmt_chan,
  output logic [NCH-1:0] flags
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_flag
      logic hit_rd, hit_acc, hit_cmt;
      assign hit_rd  = rd_start  && (rd_chan  == CW'(g));
      assign hit_acc = acc_pulse && (acc_chan == CW'(g));
      assign hit_cmt = cmt_pulse && (cmt_chan == CW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flags[g] <= 1'b0;
        else if (cal_busy) flags[g] <= 1'b0;
        else if (cal_done) flags[g] <= 1'b1;
        else if (mode_wr)  flags[g] <= 1'b0;
        else if (hit_rd)   flags[g] <= 1'b0;
        else if (hit_acc)  flags[g] <= 1'b0;
        else if (hit_cmt)  flags[g] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ready_pin.sv
module ready_pin
  import tracker_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  pin_mode_e      mode,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] flags,
  output logic           rdy_n
);
  logic any_set, all_set, assert_now;

  assign any_set    = |flags;
  assign all_set    = (|chan_en) && ((flags & chan_en) == chan_en);
  assign assert_now = (mode == PIN_ALL) ? all_set : any_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_n <= 1'b1;
    else        rdy_n <= !assert_now;
  end
endmodule

// File: rtl/chan_result_tracker.sv
module chan_result_tracker
  import tracker_pkg::*;
#(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned DW  = DEF_DW,
  parameter int unsigned NW  = DEF_NW,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wide,
  input  logic           cfg_all,
  input  logic [NCH-1:0] chan_en,
  input  logic           mode_wr,
  input  logic           cal_busy,
  input  logic           cal_done,
  input  logic           res_valid,
  output logic           res_ready,
  input  logic [CW-1:0]  res_chan,
  input  logic [DW-1:0]  res_data,
  input  logic           rd_start,
  input  logic           rd_end,
  input  logic [CW-1:0]  rd_chan,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] stat_flags,
  output logic           rdy_n
);
  logic          rd_active;
  logic [CW-1:0] rd_sel;
  logic          acc_pulse, cmt_pulse;
  logic [CW-1:0] acc_chan, cmt_chan;
  logic [DW-1:0] cmt_data;
  pin_mode_e     pin_mode;

  assign pin_mode = cfg_all ? PIN_ALL : PIN_ANY;

  result_stage #(.NCH(NCH), .DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data),
    .cal_busy(cal_busy), .mode_wr(mode_wr),
    .rd_start(rd_start), .rd_chan(rd_chan),
    .rd_active(rd_active), .rd_sel(rd_sel),
    .acc_pulse(acc_pulse), .acc_chan(acc_chan),
    .cmt_pulse(cmt_pulse), .cmt_chan(cmt_chan), .cmt_data(cmt_data)
  );

  result_bank #(.NCH(NCH), .DW(DW), .NW(NW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
    .cmt_pulse(cmt_pulse), .cmt_chan(cmt_chan), .cmt_data(cmt_data),
    .rd_start(rd_start), .rd_end(rd_end), .rd_chan(rd_chan),
    .rd_active(rd_active), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  ready_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .cal_busy(cal_busy), .cal_done(cal_done), .mode_wr(mode_wr),
    .rd_start(rd_start), .rd_chan(rd_chan),
    .acc_pulse(acc_pulse), .acc_chan(acc_chan),
    .cmt_pulse(cmt_pulse), .cmt_chan(cmt_chan),
    .flags(stat_flags)
  );

  ready_pin #(.NCH(NCH)) u_pin (
    .clk(clk), .rst_n(rst_n), .mode(pin_mode),
    .chan_en(chan_en), .flags(stat_flags), .rdy_n(rdy_n)
  );
endmodule

// File: rtl/chan_result_tracker_chk.sv
module chan_result_tracker_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_all,
  input logic [NCH-1:0] chan_en,
  input logic           mode_wr,
  input logic           cal_busy,
  input logic           cal_done,
  input logic           rd_start,
  input logic [CW-1:0]  rd_chan,
  input logic [NCH-1:0] stat_flags,
  input logic           rdy_n
);
  p_cal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |=> (stat_flags == '0));

  p_cal_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !cal_busy) |=> (stat_flags == {NCH{1'b1}}));

  p_mode_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !cal_done) |=> (stat_flags == '0));

  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !cal_done) |=> ((stat_flags & (NCH'(1) << $past(rd_chan))) == '0));

  p_pin_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_all |=> (rdy_n == !(|$past(stat_flags))));

  p_pin_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_all && (chan_en == '0)) |=> rdy_n);
endmodule

bind chan_result_tracker chan_result_tracker_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_all(cfg_all), .chan_en(chan_en),
  .mode_wr(mode_wr), .cal_busy(cal_busy), .cal_done(cal_done),
  .rd_start(rd_start), .rd_chan(rd_chan),
  .stat_flags(stat_flags), .rdy_n(rdy_n)
);

// File: tb/sim_chan_result_tracker.sv
`timescale 1ns/1ps
module sim_chan_result_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0, cfg_all = 1'b0;
  logic [7:0]  chan_en = 8'h00;
  logic        mode_wr = 1'b0, cal_busy = 1'b0, cal_done = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [2:0]  res_chan = '0;
  logic [23:0] res_data = '0;
  logic        rd_start = 1'b0, rd_end = 1'b0;
  logic [2:0]  rd_chan = '0;
  logic [23:0] rd_data;
  logic [7:0]  stat_flags;
  logic        rdy_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chan_result_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_all(cfg_all),
    .chan_en(chan_en), .mode_wr(mode_wr), .cal_busy(cal_busy),
    .cal_done(cal_done), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .rd_start(rd_start),
    .rd_end(rd_end), .rd_chan(rd_chan), .rd_data(rd_data),
    .stat_flags(stat_flags), .rdy_n(rdy_n)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] ch, output logic [23:0] val);
    rd_start = 1'b1; rd_chan = ch;
    tick();
    rd_start = 1'b0;
    val = rd_data;
    rd_end = 1'b1;
    tick();
    rd_end = 1'b0;
  endtask

  task automatic offer(input logic [2:0] ch, input logic [23:0] d);
    res_valid = 1'b1; res_chan = ch; res_data = d;
    tick();
    res_valid = 1'b0;
  endtask

  task automatic send(input logic [2:0] ch, input logic [23:0] d);
    offer(ch, d);
    tick();
  endtask

  task automatic t_reset();
    logic [23:0] v;
    check("R1 flags", stat_flags, 8'h00);
    check("R1 rdy_n", rdy_n, 1);
    do_read(3'd4, v);
    check("R1 narrow reset word", v, 24'h008000);
    cfg_wide = 1'b1;
    do_read(3'd7, v);
    check("R1 wide reset word", v, 24'h800000);
    cfg_wide = 1'b0;
  endtask

  task automatic t_update();
    logic [23:0] v;
    offer(3'd3, 24'hABCDEF);
    check("R2 flag low after take", stat_flags, 8'h00);
    tick();
    check("R2 flag set on write", stat_flags, 8'h08);
    rd_start = 1'b1; rd_chan = 3'd3;
    tick();
    rd_start = 1'b0;
    check("R3 flag clears at read start", stat_flags, 8'h00);
    check("R5 narrow store", rd_data, 24'h00ABCD);
    tick();
    check("R3 rd_data held", rd_data, 24'h00ABCD);
    rd_end = 1'b1; tick(); rd_end = 1'b0;
  endtask

  task automatic t_wide();
    logic [23:0] v;
    cfg_wide = 1'b1;
    send(3'd5, 24'h123456);
    check("R2 flag bit5", stat_flags, 8'h20);
    do_read(3'd5, v);
    check("R5 wide store", v, 24'h123456);
    cfg_wide = 1'b0;
  endtask

  task automatic t_overwrite();
    logic [23:0] v;
    send(3'd1, 24'h111100);
    check("R2 first result", stat_flags, 8'h02);
    offer(3'd1, 24'h777700);
    check("R2 overwrite drives low", stat_flags, 8'h00);
    tick();
    check("R2 overwrite sets high", stat_flags, 8'h02);
    do_read(3'd1, v);
    check("R2 newest value kept", v, 24'h007777);
  endtask

  task automatic t_drop();
    logic [23:0] v;
    send(3'd2, 24'h222200);
    rd_start = 1'b1; rd_chan = 3'd2;
    tick();
    rd_start = 1'b0;
    send(3'd2, 24'h999900);
    check("R4 flag stays low during read", stat_flags, 8'h00);
    rd_end = 1'b1; tick(); rd_end = 1'b0;
    do_read(3'd2, v);
    check("R4 open read drop", v, 24'h002222);
    rd_start = 1'b1; rd_chan = 3'd2;
    res_valid = 1'b1; res_chan = 3'd2; res_data = 24'hAAAA00;
    tick();
    rd_start = 1'b0; res_valid = 1'b0;
    rd_end = 1'b1; tick(); rd_end = 1'b0;
    tick();
    check("R4 same-cycle flag", stat_flags, 8'h00);
    do_read(3'd2, v);
    check("R4 same-cycle drop", v, 24'h002222);
    send(3'd6, 24'h666600);
    do_read(3'd6, v);
    offer(3'd6, 24'hBBBB00);
    rd_start = 1'b1; rd_chan = 3'd6;
    tick();
    rd_start = 1'b0;
    check("R4 commit-cycle read value", rd_data, 24'h006666);
    check("R4 commit-cycle flag", stat_flags, 8'h00);
    rd_end = 1'b1; tick(); rd_end = 1'b0;
    do_read(3'd6, v);
    check("R4 commit-cycle drop", v, 24'h006666);
  endtask

  task automatic t_mode_wr();
    logic [23:0] v;
    send(3'd0, 24'h0A0A00);
    send(3'd4, 24'h0B0B00);
    check("R6 flags before write", stat_flags, 8'h11);
    mode_wr = 1'b1; tick(); mode_wr = 1'b0;
    check("R6 flags cleared", stat_flags, 8'h00);
    offer(3'd4, 24'h0C0C00);
    mode_wr = 1'b1; tick(); mode_wr = 1'b0;
    tick();
    check("R6 pending result flag", stat_flags, 8'h00);
    do_read(3'd4, v);
    check("R6 pending result discarded", v, 24'h000B0B);
  endtask

  task automatic t_cal();
    logic [23:0] v;
    send(3'd7, 24'h707000);
    cal_busy = 1'b1;
    #1;
    check("R10 ready low in calibration", res_ready, 0);
    tick();
    check("R7 flags held low", stat_flags, 8'h00);
    offer(3'd7, 24'hEEEE00);
    tick();
    check("R10 offer ignored", stat_flags, 8'h00);
    cal_busy = 1'b0;
    #1;
    check("R10 ready after calibration", res_ready, 1);
    do_read(3'd7, v);
    check("R10 register untouched", v, 24'h007070);
    cal_done = 1'b1; tick(); cal_done = 1'b0;
    check("R7 all flags set", stat_flags, 8'hFF);
  endtask

  task automatic t_pin_any();
    cfg_all = 1'b0;
    tick();
    check("R8 pin low with flags", rdy_n, 0);
    mode_wr = 1'b1; tick(); mode_wr = 1'b0;
    check("R8 pin lags flags", rdy_n, 0);
    tick();
    check("R8 pin high when empty", rdy_n, 1);
    offer(3'd3, 24'h030300);
    tick();
    check("R8 pin still high at write edge", rdy_n, 1);
    tick();
    check("R8 pin low after flag", rdy_n, 0);
    mode_wr = 1'b1; tick(); mode_wr = 1'b0;
    tick();
  endtask

  task automatic t_pin_all();
    cfg_all = 1'b1; chan_en = 8'h05;
    send(3'd0, 24'h010100);
    tick();
    check("R9 pin high with one of two", rdy_n, 1);
    send(3'd2, 24'h020200);
    check("R9 flags both set", stat_flags, 8'h05);
    check("R9 pin lags", rdy_n, 1);
    tick();
    check("R9 pin low when all enabled", rdy_n, 0);
    chan_en = 8'h00;
    tick(); tick();
    check("R9 empty mask keeps pin high", rdy_n, 1);
    cfg_all = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_update();
    t_wide();
    t_overwrite();
    t_drop();
    t_mode_wr();
    t_cal();
    t_pin_any();
    t_pin_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule